// File: doc/BRIEF.md
# Processor Mailbox Channel Unit

This unit passes 32-bit messages between one local processing element and any number of remote bus masters. Two single-entry outbound mailboxes carry messages from the local element outward: a plain one, and one that raises an interrupt toward the remote side for as long as it holds a message. A four-entry inbound queue carries messages in the other direction.

The local side sees three valid/ready streams. On the two outbound write streams the unit drops `ready` while the mailbox is occupied, so the local writer stalls until a remote read empties it. Data is taken on a cycle where both `valid` and `ready` are high, and the writer must hold `valid` and the data until that cycle. On the inbound read stream the unit raises `valid` while the queue holds a message and keeps the head data steady until the local reader raises `ready`. A reader that finds the queue empty stalls until a remote write arrives.

The remote side is a small four-word register window. Writes complete in one cycle and read data is combinational. A read that empties a mailbox takes effect at the clock edge of the access cycle.

Top module: `mbx_unit`

## Requirements
- R1: After reset both outbound mailboxes are empty (`ob_ready` and `obi_ready` high), the inbound queue is empty (`ib_valid` low), `irq` is low, and the status word reads free count 4 with both valid bits clear.
- R2: A local write on the plain outbound stream is taken when `ob_ready` is high, and `ob_ready` then stays low until a remote read of register 0, which returns the message and empties the mailbox. A write offered while the mailbox is full stalls and is taken after that read.
- R3: The interrupt outbound mailbox behaves the same way through register 1. `irq` goes high in the cycle after the local write is taken and stays high until the cycle after the remote read of register 1.
- R4: The inbound queue delivers remote writes to register 2 to the local reader in arrival order and holds up to 4 messages. While `ib_valid` is high and `ib_ready` is low, `ib_data` does not change. `ib_valid` is low when the queue is empty.
- R5: A remote write to a full inbound queue, with no local read in the same cycle, replaces the newest entry and leaves the count at 4.
- R6: A remote read of an empty outbound mailbox returns the last message it held (0 after reset) and leaves it empty.
- R7: Register 3 is the status word. Bits [7:0] hold the number of free inbound slots (0 to 4), bit 8 is set while the plain outbound mailbox is full, bit 16 is set while the interrupt outbound mailbox is full, and all other bits are 0.
- R8: Remote writes to registers 0, 1 and 3 have no effect, and a remote read of register 2 returns 0.
- R9: A remote write to a full inbound queue in the same cycle as a local read is stored as a new entry behind the others, so the queue stays full and nothing is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ob_valid | input | 1 | Local write request, plain outbound mailbox |
| ob_ready | output | 1 | Plain outbound mailbox is empty and can take a write |
| ob_data | input | 32 | Message for the plain outbound mailbox |
| obi_valid | input | 1 | Local write request, interrupt outbound mailbox |
| obi_ready | output | 1 | Interrupt outbound mailbox is empty and can take a write |
| obi_data | input | 32 | Message for the interrupt outbound mailbox |
| ib_valid | output | 1 | Inbound queue holds a message |
| ib_ready | input | 1 | Local reader takes the head message |
| ib_data | output | 32 | Head message of the inbound queue |
| reg_en | input | 1 | Remote access strobe |
| reg_wr | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 2 | Register select: 0 plain out, 1 interrupt out, 2 inbound, 3 status |
| reg_wdata | input | 32 | Remote write data |
| reg_rdata | output | 32 | Remote read data, valid in the access cycle |
| irq | output | 1 | Interrupt, high while the interrupt mailbox is full |

## Verification
The bench fills the inbound queue past its depth, both with the local reader stalled and with a local read in the same cycle. A design that overwrites in the wrong case loses a message or miscounts free slots. It reads outbound mailboxes that are already empty: a design that pops again or clears the data returns the wrong value or reopens `ready` at the wrong moment. It holds a local write against a full mailbox, so a design that drops or duplicates the stalled message shows it at the next remote read. It also times `irq` around the write and read of the interrupt mailbox, and it writes to the read-only registers, where a careless decoder would corrupt a mailbox.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    RSEL_OUT     = 2'd0,
    RSEL_OUT_IRQ = 2'd1,
    RSEL_IN      = 2'd2,
    RSEL_STATUS  = 2'd3
  } rsel_e;

  localparam int STAT_FREE_LSB = 0;
  localparam int STAT_FREE_W   = 8;
  localparam int STAT_OUT_BIT  = 8;
  localparam int STAT_IRQ_BIT  = 16;
  localparam int N_OUT         = 2;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_valid,
  output logic         wr_ready,
  input  logic [W-1:0] wr_data,
  input  logic         rd_pop,
  output logic [W-1:0] held,
  output logic         full
);
  logic         full_q;
  logic [W-1:0] data_q;

  assign wr_ready = !full_q;
  assign full     = full_q;
  assign held     = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (wr_valid && !full_q) begin
        full_q <= 1'b1;
        data_q <= wr_data;
      end else if (rd_pop && full_q) begin
        full_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mbx_inq.sv
module mbx_inq #(
  parameter int W     = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     push_data,
  output logic             pop_valid,
  input  logic             pop_ready,
  output logic [W-1:0]     pop_data,
  output logic [CNT_W-1:0] free
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr, last_ptr, wr_sel;
  logic [CNT_W-1:0] cnt;
  logic             do_pop, is_full, overwrite, grow;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign do_pop    = pop_ready && (cnt != '0);
  assign is_full   = (cnt == CNT_W'(DEPTH));
  assign overwrite = push && is_full && !do_pop;
  assign grow      = push && !overwrite;
  assign last_ptr  = (wr_ptr == '0) ? PTR_W'(DEPTH - 1) : wr_ptr - 1'b1;
  assign wr_sel    = overwrite ? last_ptr : wr_ptr;

  assign pop_valid = (cnt != '0);
  assign pop_data  = mem[rd_ptr];
  assign free      = CNT_W'(DEPTH) - cnt;

  always_ff @(posedge clk) begin
    if (push) mem[wr_sel] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (grow)   wr_ptr <= ptr_inc(wr_ptr);
      if (do_pop) rd_ptr <= ptr_inc(rd_ptr);
      case ({grow, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/mbx_regif.sv
module mbx_regif
  import mbx_pkg::*;
#(
  parameter int W     = 32,
  parameter int CNT_W = 3
) (
  input  logic                 reg_en,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [N_OUT-1:0][W-1:0] out_held,
  input  logic [N_OUT-1:0]     out_full,
  input  logic [CNT_W-1:0]     in_free,
  output logic [N_OUT-1:0]     out_pop,
  output logic                 in_push,
  output logic [W-1:0]         rdata
);
  rsel_e        sel;
  logic         rd, wr;
  logic [W-1:0] status;

  assign sel = rsel_e'(reg_addr);
  assign rd  = reg_en && !reg_wr;
  assign wr  = reg_en && reg_wr;

  assign out_pop[0] = rd && (sel == RSEL_OUT);
  assign out_pop[1] = rd && (sel == RSEL_OUT_IRQ);
  assign in_push    = wr && (sel == RSEL_IN);

  always_comb begin
    status = '0;
    status[STAT_FREE_LSB +: CNT_W] = in_free;
    status[STAT_OUT_BIT]           = out_full[0];
    status[STAT_IRQ_BIT]           = out_full[1];
  end

  always_comb begin
    case (sel)
      RSEL_OUT:     rdata = out_held[0];
      RSEL_OUT_IRQ: rdata = out_held[1];
      RSEL_STATUS:  rdata = status;
      default:      rdata = '0;
    endcase
  end
endmodule

// File: rtl/mbx_unit.sv
module mbx_unit
  import mbx_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int IN_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ob_valid,
  output logic              ob_ready,
  input  logic [DATA_W-1:0] ob_data,
  input  logic              obi_valid,
  output logic              obi_ready,
  input  logic [DATA_W-1:0] obi_data,
  output logic              ib_valid,
  input  logic              ib_ready,
  output logic [DATA_W-1:0] ib_data,
  input  logic              reg_en,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  localparam int CNT_W = $clog2(IN_DEPTH + 1);

  logic [N_OUT-1:0]             wv, wr_rdy, full, pop;
  logic [N_OUT-1:0][DATA_W-1:0] wd, held;
  logic [CNT_W-1:0]             free;
  logic                         push;

  assign wv[0] = ob_valid;
  assign wv[1] = obi_valid;
  assign wd[0] = ob_data;
  assign wd[1] = obi_data;
  assign ob_ready  = wr_rdy[0];
  assign obi_ready = wr_rdy[1];
  assign irq       = full[1];

  for (genvar g = 0; g < N_OUT; g++) begin : g_out
    mbx_slot #(.W(DATA_W)) u_slot (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_valid(wv[g]),
      .wr_ready(wr_rdy[g]),
      .wr_data (wd[g]),
      .rd_pop  (pop[g]),
      .held    (held[g]),
      .full    (full[g])
    );
  end

  mbx_inq #(.W(DATA_W), .DEPTH(IN_DEPTH)) u_inq (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push),
    .push_data(reg_wdata),
    .pop_valid(ib_valid),
    .pop_ready(ib_ready),
    .pop_data (ib_data),
    .free     (free)
  );

  mbx_regif #(.W(DATA_W), .CNT_W(CNT_W)) u_regif (
    .reg_en  (reg_en),
    .reg_wr  (reg_wr),
    .reg_addr(reg_addr),
    .out_held(held),
    .out_full(full),
    .in_free (free),
    .out_pop (pop),
    .in_push (push),
    .rdata   (reg_rdata)
  );
endmodule

// File: rtl/mbx_unit_chk.sv
module mbx_unit_chk #(
  parameter int DATA_W   = 32,
  parameter int IN_DEPTH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ob_valid,
  input logic              ob_ready,
  input logic [DATA_W-1:0] ob_data,
  input logic              obi_valid,
  input logic              obi_ready,
  input logic [DATA_W-1:0] obi_data,
  input logic              ib_valid,
  input logic              ib_ready,
  input logic [DATA_W-1:0] ib_data,
  input logic              reg_en,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic [DATA_W-1:0] reg_rdata,
  input logic              irq
);
  logic rd0, rd1, wr_in;
  assign rd0   = reg_en && !reg_wr && (reg_addr == 2'd0);
  assign rd1   = reg_en && !reg_wr && (reg_addr == 2'd1);
  assign wr_in = reg_en && reg_wr && (reg_addr == 2'd2);

  AST_OUT_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
    ob_valid && ob_ready |=> !ob_ready); // R2
  AST_IRQ_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
    obi_valid && obi_ready |=> irq); // R3
  AST_IRQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    rd1 && irq |=> !irq); // R3
  AST_IN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ib_valid && !ib_ready && !wr_in |=> ib_valid && $stable(ib_data)); // R4
  AST_IN_ARRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    wr_in |=> ib_valid); // R4
  AST_EMPTY_READ_NOP: assert property (@(posedge clk) disable iff (!rst_n)
    rd0 && ob_ready && !ob_valid |=> ob_ready); // R6
  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == 2'd3 |-> reg_rdata[7:0] <= 8'(IN_DEPTH)); // R7
endmodule

bind mbx_unit mbx_unit_chk #(.DATA_W(DATA_W), .IN_DEPTH(IN_DEPTH)) u_chk (.*);

// File: tb/mbx_unit_bench.sv
module mbx_unit_bench;
  localparam int W = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ob_valid = 0, obi_valid = 0, ib_ready = 0;
  logic [W-1:0] ob_data = '0, obi_data = '0, reg_wdata = '0;
  logic reg_en = 0, reg_wr = 0;
  logic [1:0] reg_addr = '0;
  logic ob_ready, obi_ready, ib_valid, irq;
  logic [W-1:0] ib_data, reg_rdata;

  int n_run = 0, n_fail = 0;
  logic [W-1:0] exp_q[$];
  string cur_req = "R4";
  logic [W-1:0] v;

  always #2.5 clk = ~clk;

  mbx_unit u_mbx_unit (
    .clk(clk), .rst_n(rst_n),
    .ob_valid(ob_valid), .ob_ready(ob_ready), .ob_data(ob_data),
    .obi_valid(obi_valid), .obi_ready(obi_ready), .obi_data(obi_data),
    .ib_valid(ib_valid), .ib_ready(ib_ready), .ib_data(ib_data),
    .reg_en(reg_en), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] expv);
    n_run++;
    if (act !== expv) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic rread(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk);
    reg_en = 1; reg_wr = 0; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_en = 0;
  endtask

  // drives a remote write; inbound writes update the scoreboard after the monitor's pop
  task automatic rwrite(input logic [1:0] a, input logic [W-1:0] d, input logic with_pop);
    @(negedge clk);
    reg_en = 1; reg_wr = 1; reg_addr = a; reg_wdata = d;
    if (with_pop) ib_ready = 1;
    #2;
    if (a == 2'd2) begin
      if (exp_q.size() == 4) exp_q[$] = d;
      else exp_q.push_back(d);
    end
    @(negedge clk);
    reg_en = 0; reg_wr = 0;
    if (with_pop) ib_ready = 0;
  endtask

  task automatic lwrite(input logic irq_box, input logic [W-1:0] d);
    @(negedge clk);
    if (irq_box) begin obi_valid = 1; obi_data = d; end
    else begin ob_valid = 1; ob_data = d; end
    while (!(irq_box ? obi_ready : ob_ready)) @(negedge clk);
    @(negedge clk);
    ob_valid = 0; obi_valid = 0;
  endtask

  task automatic drain();
    ib_ready = 1;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
    ib_ready = 0;
  endtask

  // scoreboard monitor: compares each local handshake with the oldest expected item
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && ib_valid && ib_ready) begin
        if (exp_q.size() == 0) check(cur_req, ib_data, 'x);
        else check(cur_req, ib_data, exp_q.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1", {ob_ready, obi_ready, ib_valid, irq}, 4'b1100);
    rread(2'd3, v); check("R1", v, 32'h4);
    // R6 empty read after reset
    rread(2'd0, v); check("R6", v, 32'h0);
    check("R6", ob_ready, 1'b1);
    // R2 plain outbound
    lwrite(0, 32'hA5A5_0001);
    check("R2", ob_ready, 1'b0);
    rread(2'd3, v); check("R7", v, 32'h104);
    rread(2'd0, v); check("R2", v, 32'hA5A5_0001);
    check("R2", ob_ready, 1'b1);
    rread(2'd0, v); check("R6", v, 32'hA5A5_0001);
    check("R6", ob_ready, 1'b1);
    // R2 stall on full
    lwrite(0, 32'h0000_B00B);
    @(negedge clk); ob_valid = 1; ob_data = 32'h0000_C0C0;
    repeat (3) @(negedge clk);
    check("R2", ob_ready, 1'b0);
    ob_valid = 1;
    rread(2'd0, v); check("R2", v, 32'h0000_B00B);
    while (!ob_ready) @(negedge clk);
    @(negedge clk); ob_valid = 0;
    rread(2'd0, v); check("R2", v, 32'h0000_C0C0);
    // R3 interrupt mailbox
    check("R3", irq, 1'b0);
    lwrite(1, 32'h1111_D00D);
    check("R3", {irq, obi_ready}, 2'b10);
    rread(2'd3, v); check("R7", v, 32'h1_0004);
    rread(2'd1, v); check("R3", v, 32'h1111_D00D);
    check("R3", {irq, obi_ready}, 2'b01);
    // R8 writes to read-only registers and read of the inbound register
    rwrite(2'd0, 32'hDEAD_0000, 0);
    rwrite(2'd1, 32'hDEAD_0001, 0);
    rwrite(2'd3, 32'hDEAD_0003, 0);
    check("R8", {ob_ready, obi_ready, irq, ib_valid}, 4'b1100);
    rread(2'd0, v); check("R8", v, 32'h0000_C0C0);
    rread(2'd3, v); check("R8", v, 32'h4);
    rread(2'd2, v); check("R8", v, 32'h0);
    // R4 inbound ordering and hold while stalled
    cur_req = "R4";
    ib_ready = 1; @(negedge clk); check("R4", ib_valid, 1'b0); ib_ready = 0;
    rwrite(2'd2, 32'h4000_0001, 0);
    rwrite(2'd2, 32'h4000_0002, 0);
    rwrite(2'd2, 32'h4000_0003, 0);
    rread(2'd3, v); check("R7", v, 32'h1);
    check("R4", ib_data, 32'h4000_0001);
    repeat (2) @(negedge clk);
    check("R4", {31'b0, ib_valid}, 32'h1);
    check("R4", ib_data, 32'h4000_0001);
    drain();
    check("R4", ib_valid, 1'b0);
    rread(2'd3, v); check("R4", v, 32'h4);
    // R5 overwrite newest when full
    cur_req = "R5";
    for (int i = 0; i < 6; i++) rwrite(2'd2, 32'h5000_0000 + i, 0);
    rread(2'd3, v); check("R5", v, 32'h0);
    drain();
    // R9 full queue, write with simultaneous local read
    cur_req = "R9";
    for (int i = 0; i < 4; i++) rwrite(2'd2, 32'h9000_0000 + i, 0);
    rwrite(2'd2, 32'h9000_00FF, 1);
    rread(2'd3, v); check("R9", v, 32'h0);
    drain();
    check("R9", ib_valid, 1'b0);
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule